// File: doc/BRIEF.md
# Video Sync Front End

This block sits between the sync inputs of a display and its timing logic. It accepts a horizontal and a vertical sync line, or a composite sync on the horizontal line alone. It finds the polarity of each line by comparing how long the line stays high with how long it stays low, and inverts it if needed, so that every later stage sees short active-high pulses. In composite mode it recovers vertical sync from the horizontal line by treating any active pulse longer than a set threshold as a frame pulse.

For each sync the block keeps a presence flag. It measures the frame period in clocks and the number of line pulses per frame. Each measurement is captured into its output register just before its counter restarts. A line period that is too short is flagged, and a single validity bit tells the host whether the measurements can be trusted. When either sync is missing, a free-running generator makes pseudo horizontal and vertical syncs. An output-select pin chooses whether the two sync outputs carry the processed inputs or the generated signals. A sticky frame interrupt can be raised at every frame start.

Top module: `sync_proc`

## Requirements
- R1: Polarity is decided by a two-step vote taken at each rising edge of the raw input. The vote moves toward "inverted" when the low phase that just ended was shorter than the last high phase, and toward "normal" otherwise. The flag (`h_pol`/`v_pol`, 1 = inverted input) is 1 once two inverted votes outweigh the normal ones. The corrected sync is always active high, so a normal input passes as it is and an inverted one is flipped; an active pulse of width W appears as a high pulse of width W.
- R2: `vfreq` holds the number of clocks between the two most recent vertical sync starts, as an unsigned 13-bit value.
- R3: When the frame interval exceeds 8191 clocks, `vfreq` reads 8191 instead of wrapping.
- R4: `lines` holds the number of horizontal sync starts counted in the previous frame. A start that coincides with a frame start counts toward the new frame. `vfreq` and `lines` change only on a vertical sync start.
- R5: `h_present` clears when the corrected horizontal sync has no rising edge for 1024 clocks, and `v_present` clears after 16384 clocks without one. Each flag sets again on the next rising edge.
- R6: `h_too_fast` is 1 when the last horizontal period was shorter than 64 clocks. `meas_valid` is 1 only when both presence flags are 1 and `h_too_fast` is 0.
- R7: With `csync_mode` = 1, the vertical sync is taken from the horizontal input: it starts once the corrected horizontal sync has been high for 50 clocks. `vsync_in` then has no effect.
- R8: While either presence flag is 0, the generator produces a pseudo vertical sync with a period of 31488 clocks and a pseudo horizontal sync with a period of 640 clocks. While both flags are 1, both generated syncs stay low.
- R9: With `out_sel` = 1, `hsync_out`/`vsync_out` carry the corrected horizontal sync and the processed vertical sync. With `out_sel` = 0 they carry the generated syncs. The outputs are registered.
- R10: `frame_irq` is set at a vertical sync start when `vs_irq_en` = 1, and stays set until `irq_clr` is pulsed. If a set and a clear fall in the same cycle, the set wins. With `vs_irq_en` = 0 the flag is never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_in | input | 1 | Horizontal or composite sync, either polarity |
| vsync_in | input | 1 | Vertical sync, either polarity |
| out_sel | input | 1 | 1 = processed syncs on the outputs, 0 = generated |
| csync_mode | input | 1 | 1 = take vertical sync from the horizontal input |
| vs_irq_en | input | 1 | Frame interrupt enable |
| irq_clr | input | 1 | Clears the frame interrupt |
| hsync_out | output | 1 | Horizontal sync to the display, active high |
| vsync_out | output | 1 | Vertical sync to the display, active high |
| h_pol | output | 1 | 1 = horizontal input found inverted |
| v_pol | output | 1 | 1 = vertical input found inverted |
| h_present | output | 1 | Horizontal sync present |
| v_present | output | 1 | Vertical sync present |
| h_too_fast | output | 1 | Line period below the minimum |
| meas_valid | output | 1 | Measurements trustworthy |
| vfreq | output | 13 | Frame period in clocks, saturating |
| lines | output | 11 | Line pulses in the last frame |
| frame_irq | output | 1 | Sticky frame interrupt |

## Verification
An input edge reaches `hsync_out`/`vsync_out` three clocks later: the input register, the correction register and the output register. That delay is the same on both paths, so the checks time pulses and compare rise-to-rise intervals on the outputs instead of fixed cycle positions. A polarity reversal settles after two periods of the affected sync. A measurement is correct from the second frame start after a change, so each scenario waits several frames before it reads `vfreq`, `lines` and the flags. A loss of presence is due one window plus the pipeline after the last edge, and the bench samples a few hundred clocks beyond that point. A generator period is taken between two consecutive rising edges of the output.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int VF_W = 13;

  typedef enum logic [1:0] {
    VOTE_NORM2 = 2'd0,
    VOTE_NORM1 = 2'd1,
    VOTE_INV1  = 2'd2,
    VOTE_INV2  = 2'd3
  } vote_t;

  function automatic vote_t vote_step(vote_t v, logic toward_inv);
    vote_t r;
    r = v;
    if (toward_inv) begin
      if (v != VOTE_INV2) r = vote_t'(v + 2'd1);
    end else begin
      if (v != VOTE_NORM2) r = vote_t'(v - 2'd1);
    end
    return r;
  endfunction
endpackage

// File: rtl/sp_polarity.sv
module sp_polarity #(
  parameter int RUN_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_raw,
  output logic corr,
  output logic inverted
);
  import sp_pkg::*;
  localparam logic [RUN_W-1:0] RMAX = '1;

  logic raw_q, raw_d;
  logic [RUN_W-1:0] run_len, hi_len;
  vote_t vote;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q   <= 1'b0;
      raw_d   <= 1'b0;
      run_len <= '0;
      hi_len  <= '0;
      vote    <= VOTE_NORM2;
      corr    <= 1'b0;
    end else begin
      raw_q <= sync_raw;
      raw_d <= raw_q;
      if (raw_q != raw_d) run_len <= RUN_W'(1);
      else if (run_len != RMAX) run_len <= run_len + RUN_W'(1);
      if (!raw_q && raw_d) hi_len <= run_len;
      if (raw_q && !raw_d) vote <= vote_step(vote, run_len < hi_len);
      corr <= raw_q ^ vote[1];
    end
  end

  assign inverted = vote[1];

  // R1: the flag never jumps straight between the two strong states
  a_r1_vote_steps: assert property (@(posedge clk) disable iff (rst)
    (vote == VOTE_NORM2) |=> (vote != VOTE_INV2));
endmodule

// File: rtl/sp_presence.sv
module sp_presence #(
  parameter int WIN = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic start,
  output logic present
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WIN);

  logic sig_d;
  logic [CW-1:0] quiet;

  assign start = sig & ~sig_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_d   <= 1'b0;
      quiet   <= '0;
      present <= 1'b0;
    end else begin
      sig_d <= sig;
      if (start) begin
        quiet   <= '0;
        present <= 1'b1;
      end else if (quiet == LIMIT) begin
        present <= 1'b0;
      end else begin
        quiet <= quiet + CW'(1);
      end
    end
  end

  // R5: a rising edge always marks the sync present on the next cycle
  a_r5_edge_sets: assert property (@(posedge clk) disable iff (rst)
    start |=> present);
endmodule

// File: rtl/sp_csep.sv
module sp_csep #(
  parameter int VTH = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic hin,
  output logic vsep
);
  localparam int AW = $clog2(VTH + 1);
  localparam logic [AW-1:0] AMAX = AW'(VTH);

  logic [AW-1:0] act;

  always_ff @(posedge clk) begin
    if (rst) begin
      act  <= '0;
      vsep <= 1'b0;
    end else begin
      if (!hin) act <= '0;
      else if (act != AMAX) act <= act + AW'(1);
      vsep <= hin && (act == AMAX);
    end
  end

  // R7: a separated frame pulse only follows an active composite level
  a_r7_sep_from_active: assert property (@(posedge clk) disable iff (rst)
    $rose(vsep) |-> $past(hin));
endmodule

// File: rtl/sp_meas.sv
module sp_meas #(
  parameter int CNT_W  = 13,
  parameter int LINE_W = 11,
  parameter int HMIN   = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              v_start,
  input  logic              h_start,
  output logic [CNT_W-1:0]  vfreq,
  output logic [LINE_W-1:0] lines,
  output logic              too_fast
);
  localparam logic [CNT_W-1:0]  CMAX = '1;
  localparam logic [LINE_W-1:0] LMAX = '1;
  localparam int HW = $clog2(HMIN + 1);
  localparam logic [HW-1:0] HMAX = HW'(HMIN);
  localparam logic [HW-1:0] HLIM = HW'(HMIN - 1);

  logic [CNT_W-1:0]  fcnt;
  logic [LINE_W-1:0] lcnt;
  logic [HW-1:0]     hpc;

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt  <= '0;
      vfreq <= '0;
      lcnt  <= '0;
      lines <= '0;
    end else if (v_start) begin
      vfreq <= (fcnt == CMAX) ? CMAX : fcnt + CNT_W'(1);
      fcnt  <= '0;
      lines <= lcnt;
      lcnt  <= h_start ? LINE_W'(1) : '0;
    end else begin
      if (fcnt != CMAX) fcnt <= fcnt + CNT_W'(1);
      if (h_start && lcnt != LMAX) lcnt <= lcnt + LINE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hpc      <= HMAX;
      too_fast <= 1'b0;
    end else if (h_start) begin
      too_fast <= hpc < HLIM;
      hpc      <= '0;
    end else if (hpc != HMAX) begin
      hpc <= hpc + HW'(1);
    end
  end

  // R4: measurements move only at a frame start
  a_r4_hold_between_frames: assert property (@(posedge clk) disable iff (rst)
    !v_start |=> ($stable(vfreq) && $stable(lines)));
endmodule

// File: rtl/sp_freegen.sv
module sp_freegen #(
  parameter int VPER = 31488,
  parameter int VPW  = 200,
  parameter int HPER = 640,
  parameter int HPW  = 48
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic gen_v,
  output logic gen_h
);
  localparam int VW = $clog2(VPER);
  localparam int HW = $clog2(HPER);
  localparam logic [VW-1:0] VLAST = VW'(VPER - 1);
  localparam logic [HW-1:0] HLAST = HW'(HPER - 1);

  logic [VW-1:0] vcnt;
  logic [HW-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      vcnt  <= '0;
      hcnt  <= '0;
      gen_v <= 1'b0;
      gen_h <= 1'b0;
    end else begin
      vcnt  <= (vcnt == VLAST) ? '0 : vcnt + VW'(1);
      hcnt  <= (hcnt == HLAST) ? '0 : hcnt + HW'(1);
      gen_v <= vcnt < VW'(VPW);
      gen_h <= hcnt < HW'(HPW);
    end
  end

  // R8: an idle generator drives nothing
  a_r8_idle_low: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!gen_v && !gen_h));
endmodule

// File: rtl/sync_proc.sv
module sync_proc #(
  parameter int CNT_W  = sp_pkg::VF_W,
  parameter int LINE_W = 11,
  parameter int H_LOSS = 1024,
  parameter int V_LOSS = 16384,
  parameter int HMIN   = 64,
  parameter int VTH    = 50,
  parameter int VPER   = 31488,
  parameter int HPER   = 640
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic              out_sel,
  input  logic              csync_mode,
  input  logic              vs_irq_en,
  input  logic              irq_clr,
  output logic              hsync_out,
  output logic              vsync_out,
  output logic              h_pol,
  output logic              v_pol,
  output logic              h_present,
  output logic              v_present,
  output logic              h_too_fast,
  output logic              meas_valid,
  output logic [CNT_W-1:0]  vfreq,
  output logic [LINE_W-1:0] lines,
  output logic              frame_irq
);
  logic h_corr, v_corr, v_sep, v_src;
  logic h_start, v_start, gen_v, gen_h;

  sp_polarity u_hpol (.clk(clk), .rst(rst), .sync_raw(hsync_in), .corr(h_corr), .inverted(h_pol));
  sp_polarity u_vpol (.clk(clk), .rst(rst), .sync_raw(vsync_in), .corr(v_corr), .inverted(v_pol));

  sp_csep #(.VTH(VTH)) u_sep (.clk(clk), .rst(rst), .hin(h_corr), .vsep(v_sep));

  assign v_src = csync_mode ? v_sep : v_corr;

  sp_presence #(.WIN(H_LOSS)) u_hdet (.clk(clk), .rst(rst), .sig(h_corr), .start(h_start), .present(h_present));
  sp_presence #(.WIN(V_LOSS)) u_vdet (.clk(clk), .rst(rst), .sig(v_src), .start(v_start), .present(v_present));

  sp_meas #(.CNT_W(CNT_W), .LINE_W(LINE_W), .HMIN(HMIN)) u_meas (
    .clk(clk), .rst(rst), .v_start(v_start), .h_start(h_start),
    .vfreq(vfreq), .lines(lines), .too_fast(h_too_fast));

  sp_freegen #(.VPER(VPER), .HPER(HPER)) u_gen (
    .clk(clk), .rst(rst), .run(!(h_present && v_present)), .gen_v(gen_v), .gen_h(gen_h));

  assign meas_valid = h_present && v_present && !h_too_fast;

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_out <= 1'b0;
      vsync_out <= 1'b0;
      frame_irq <= 1'b0;
    end else begin
      hsync_out <= out_sel ? h_corr : gen_h;
      vsync_out <= out_sel ? v_src : gen_v;
      if (v_start && vs_irq_en) frame_irq <= 1'b1;
      else if (irq_clr) frame_irq <= 1'b0;
    end
  end

  // R10: with the enable off an idle interrupt stays idle
  a_r10_no_irq_when_off: assert property (@(posedge clk) disable iff (rst)
    (!frame_irq && !vs_irq_en) |=> !frame_irq);
endmodule

// File: tb/sim_sync_proc.sv
module sim_sync_proc;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsync_in = 1'b0, vsync_in = 1'b0;
  logic out_sel = 1'b1, csync_mode = 1'b0, vs_irq_en = 1'b0, irq_clr = 1'b0;
  logic hsync_out, vsync_out, h_pol, v_pol, h_present, v_present;
  logic h_too_fast, meas_valid, frame_irq;
  logic [12:0] vfreq;
  logic [10:0] lines;

  int errors = 0, checks = 0;
  int t = 0;
  int hper = 100, hwid = 8, vper = 2000, vwid = 150;
  bit hon = 0, von = 0, hinv = 0, vinv = 0, comp = 0;

  always #2.5 clk = ~clk;

  sync_proc u0 (
    .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .out_sel(out_sel), .csync_mode(csync_mode), .vs_irq_en(vs_irq_en), .irq_clr(irq_clr),
    .hsync_out(hsync_out), .vsync_out(vsync_out), .h_pol(h_pol), .v_pol(v_pol),
    .h_present(h_present), .v_present(v_present), .h_too_fast(h_too_fast),
    .meas_valid(meas_valid), .vfreq(vfreq), .lines(lines), .frame_irq(frame_irq));

  // Stimulus: patterns derived from one free cycle counter, driven on the falling edge.
  // Composite adds a 250-clock active level every 2000 clocks to the line pulses.
  initial begin
    forever begin
      @(negedge clk);
      t = t + 1;
      hsync_in = ((hon && ((t % hper) < hwid)) || (comp && ((t % 2000) < 250))) ^ hinv;
      vsync_in = (von && ((t % vper) < vwid)) ^ vinv;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  task automatic chk(string req, int act, int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic pick(int which);
    return (which == 0) ? hsync_out : vsync_out;
  endfunction

  task automatic wait_rise(int which);
    logic prev, cur;
    prev = pick(which);
    forever begin
      @(negedge clk);
      cur = pick(which);
      if (cur && !prev) break;
      prev = cur;
    end
  endtask

  task automatic high_width(int which, output int w);
    wait_rise(which);
    w = 1;
    forever begin
      @(negedge clk);
      if (pick(which)) w = w + 1;
      else break;
    end
  endtask

  task automatic rise_period(int which, output int p);
    logic prev, cur;
    wait_rise(which);
    p = 0;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      p = p + 1;
      cur = pick(which);
      if (cur && !prev) break;
      prev = cur;
    end
  endtask

  task automatic t_reset();
    wait_cyc(2);
    chk("R5 h_present after reset", int'(h_present), 0);
    chk("R5 v_present after reset", int'(v_present), 0);
    chk("R2 vfreq after reset", int'(vfreq), 0);
    chk("R10 irq after reset", int'(frame_irq), 0);
    chk("R6 meas_valid after reset", int'(meas_valid), 0);
  endtask

  task automatic t_normal();
    int w;
    hon = 1; von = 1;
    wait_cyc(8000);
    chk("R1 h_pol normal", int'(h_pol), 0);
    chk("R1 v_pol normal", int'(v_pol), 0);
    chk("R5 h_present", int'(h_present), 1);
    chk("R5 v_present", int'(v_present), 1);
    chk("R2 vfreq 2000", int'(vfreq), 2000);
    chk("R4 lines 20", int'(lines), 20);
    chk("R6 meas_valid", int'(meas_valid), 1);
    high_width(0, w); chk("R9 hsync_out width", w, 8);
    high_width(1, w); chk("R9 vsync_out width", w, 150);
  endtask

  task automatic t_inverted();
    int w;
    hinv = 1; vinv = 1;
    wait_cyc(12000);
    chk("R1 h_pol inverted", int'(h_pol), 1);
    chk("R1 v_pol inverted", int'(v_pol), 1);
    chk("R2 vfreq inverted input", int'(vfreq), 2000);
    high_width(0, w); chk("R1 corrected h width", w, 8);
    high_width(1, w); chk("R1 corrected v width", w, 150);
    hinv = 0; vinv = 0;
    wait_cyc(6000);
  endtask

  task automatic t_saturate();
    vper = 8400;
    wait_cyc(30000);
    chk("R3 vfreq saturates", int'(vfreq), 8191);
    chk("R4 lines 84", int'(lines), 84);
    vper = 2000;
    wait_cyc(6000);
  endtask

  task automatic t_fast();
    hper = 40; hwid = 4;
    wait_cyc(6000);
    chk("R6 too_fast set", int'(h_too_fast), 1);
    chk("R6 meas_valid low", int'(meas_valid), 0);
    hper = 100; hwid = 8;
    wait_cyc(3000);
    chk("R6 too_fast clears", int'(h_too_fast), 0);
    chk("R6 meas_valid back", int'(meas_valid), 1);
  endtask

  task automatic t_composite();
    comp = 1; csync_mode = 1; vper = 3000;
    wait_cyc(8000);
    chk("R7 vfreq from composite", int'(vfreq), 2000);
    chk("R7 lines composite", int'(lines), 18);
    chk("R7 v_present composite", int'(v_present), 1);
    comp = 0; csync_mode = 0; vper = 2000;
    wait_cyc(6000);
  endtask

  task automatic t_fallback();
    int p;
    hon = 0; out_sel = 0;
    wait_cyc(1200);
    chk("R5 h_present lost", int'(h_present), 0);
    chk("R6 meas_valid on loss", int'(meas_valid), 0);
    rise_period(0, p); chk("R8 pseudo h period", p, 640);
    rise_period(1, p); chk("R8 pseudo v period", p, 31488);
  endtask

  task automatic t_regain();
    int highs;
    hon = 1; out_sel = 1;
    wait_cyc(500);
    chk("R5 h_present regained", int'(h_present), 1);
    out_sel = 0;
    wait_cyc(3);
    highs = 0;
    for (int i = 0; i < 2500; i++) begin
      @(negedge clk);
      if (hsync_out || vsync_out) highs = highs + 1;
    end
    chk("R8 generator idle when present", highs, 0);
    out_sel = 1;
    wait_cyc(3);
  endtask

  task automatic t_irq();
    vs_irq_en = 0;
    wait_cyc(4500);
    chk("R10 no irq while disabled", int'(frame_irq), 0);
    vs_irq_en = 1;
    wait_cyc(2100);
    chk("R10 irq set", int'(frame_irq), 1);
    wait_rise(1);
    wait_cyc(500);
    irq_clr = 1;
    wait_cyc(1);
    irq_clr = 0;
    wait_cyc(3);
    chk("R10 irq cleared", int'(frame_irq), 0);
    wait_cyc(2100);
    chk("R10 irq set again", int'(frame_irq), 1);
  endtask

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    t_reset();
    t_normal();
    t_inverted();
    t_saturate();
    t_fast();
    t_composite();
    t_fallback();
    t_regain();
    t_irq();
    summary();
    $finish;
  end
endmodule